// File: doc/BRIEF.md
# Parallel PRBS-7 Word Generator

This block produces a maximum-length pseudo-random binary sequence of order 7 and hands it out several bits at a time. Every enabled clock advances the sequence by a whole output word, so a serializer running at a multiple of the word clock can be fed at line rate without running a one-bit shift register at that rate. The word width is a parameter: 8 bits for a byte datapath, 16 bits for a wider datapath at a lower word clock.

Inside, a 7-bit state register holds the most recent seven sequence bits. A combinational chain, unrolled once per output bit, applies the single-step recurrence WIDTH times and yields both the next state and the word of newly generated bits. The first bit of each word sits in the MSB, so shifting the word out MSB-first gives the serial sequence in order.

Top module: `prbs7_par_gen`

## Requirements
- R1: The serial sequence follows the recurrence of polynomial x^7 + x^6 + 1: with state s[6:0], the new bit is b = s[6] XOR s[5] and the next state is {s[5:0], b}.
- R2: After reset is released, the first enabled clock puts on data_o the first WIDTH bits generated from the seed, the earliest bit in data_o[WIDTH-1] and the latest in data_o[0].
- R3: Each further enabled clock puts on data_o the next WIDTH bits of the sequence, with no bit skipped or repeated between words.
- R4: While rst_i is high at a clock edge, data_o is cleared to all zeros and the state is loaded with the seed 7'h7F.
- R5: A clock with en_i low changes neither data_o nor the state; the next enabled clock continues from where the sequence stopped.
- R6: With WIDTH = 8, the word sequence repeats exactly every 127 enabled clocks (word k+127 equals word k).
- R7: The state is never all zeros, so the output stream never contains seven zero bits in a row.
- R8: With WIDTH = 16, data_o carries the same serial sequence, 16 bits per enabled clock.
- R9: A reset applied in mid-run restarts the sequence from the seed, so the next enabled word equals the first word after the initial reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Word clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Advance the sequence by one word on this clock |
| data_o | output | WIDTH | Registered word of sequence bits, earliest bit in MSB |

## Verification
The bench runs an 8-bit and a 16-bit instance side by side against a bit-serial model of the recurrence, so a swapped tap, a reversed bit order inside the word or an off-by-one in the unrolled chain shows up as a mismatch on the very first word. It records three hundred 8-bit words to confirm the 127-word period, which a non-maximal polynomial or a wrong seed would break, and counts the longest zero run, which a design that could fall into the all-zero state would stretch without limit. Enable is held low and toggled every cycle to catch a design that advances while idle or drops a word on resume, and a reset in mid-run must bring back the first word exactly.

// File: rtl/prbs7_pkg.sv
package prbs7_pkg;

   localparam int unsigned ORDER  = 7;
   localparam int unsigned TAP_HI = 6;
   localparam int unsigned TAP_LO = 5;

   typedef logic [ORDER-1:0] prbs_state_t;

   localparam prbs_state_t DEFAULT_SEED = prbs_state_t'(7'h7F);

   function automatic logic fb_bit(input prbs_state_t s);
      return s[TAP_HI] ^ s[TAP_LO];
   endfunction

   function automatic prbs_state_t step_once(input prbs_state_t s);
      return {s[ORDER-2:0], fb_bit(s)};
   endfunction

endpackage

// File: rtl/prbs7_step_unroll.sv
module prbs7_step_unroll
   import prbs7_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  prbs_state_t        state_i,
   output prbs_state_t        state_o,
   output logic [WIDTH-1:0]   word_o
);

   localparam int unsigned STAGES = WIDTH;

   prbs_state_t chain [0:STAGES];
   logic [STAGES-1:0] gen_bits;

   assign chain[0] = state_i;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         assign gen_bits[STAGES-1-i] = fb_bit(chain[i]);
         assign chain[i+1]           = step_once(chain[i]);
      end
   endgenerate

   assign state_o = chain[STAGES];
   assign word_o  = gen_bits;

endmodule

// File: rtl/prbs7_state_reg.sv
module prbs7_state_reg
   import prbs7_pkg::*;
#(
   parameter int unsigned WIDTH = 8,
   parameter prbs_state_t SEED  = DEFAULT_SEED
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic               en_i,
   input  prbs_state_t        nxt_state_i,
   input  logic [WIDTH-1:0]   nxt_word_i,
   output prbs_state_t        state_q,
   output logic [WIDTH-1:0]   word_q
);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         state_q <= SEED;
         word_q  <= '0;
      end else if (en_i) begin
         state_q <= nxt_state_i;
         word_q  <= nxt_word_i;
      end
   end

endmodule

// File: rtl/prbs7_par_gen.sv
module prbs7_par_gen
   import prbs7_pkg::*;
#(
   parameter int unsigned WIDTH = 8,
   parameter prbs_state_t SEED  = DEFAULT_SEED
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic               en_i,
   output logic [WIDTH-1:0]   data_o
);

   localparam int unsigned MIN_WIDTH = ORDER;
   localparam int unsigned MAX_WIDTH = 64;

   generate
      if (WIDTH < MIN_WIDTH || WIDTH > MAX_WIDTH) begin : g_bad_width
         $error("prbs7_par_gen: WIDTH out of supported range");
      end
      if (SEED == '0) begin : g_bad_seed
         $error("prbs7_par_gen: SEED must be nonzero");
      end
   endgenerate

   prbs_state_t       state_q;
   prbs_state_t       state_nxt;
   logic [WIDTH-1:0]  word_nxt;

   prbs7_step_unroll #(
      .WIDTH (WIDTH)
   ) u_unroll (
      .state_i (state_q),
      .state_o (state_nxt),
      .word_o  (word_nxt)
   );

   prbs7_state_reg #(
      .WIDTH (WIDTH),
      .SEED  (SEED)
   ) u_reg (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .en_i        (en_i),
      .nxt_state_i (state_nxt),
      .nxt_word_i  (word_nxt),
      .state_q     (state_q),
      .word_q      (data_o)
   );

endmodule

// File: rtl/prbs7_par_gen_chk.sv
module prbs7_par_gen_chk
   import prbs7_pkg::*;
#(
   parameter int unsigned WIDTH = 8,
   parameter prbs_state_t SEED  = DEFAULT_SEED
) (
   input logic              clk_i,
   input logic              rst_i,
   input logic              en_i,
   input logic [WIDTH-1:0]  data_o,
   input prbs_state_t       state_q
);

   AST_STATE_NONZERO: assert property (@(posedge clk_i) disable iff (rst_i)
      state_q != '0); // R7

   AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
      !en_i |=> ($stable(data_o) && $stable(state_q))); // R5

   AST_FIRST_BIT: assert property (@(posedge clk_i) disable iff (rst_i)
      en_i |=> data_o[WIDTH-1] == ($past(state_q[6]) ^ $past(state_q[5]))); // R1

   AST_WORD_TAIL: assert property (@(posedge clk_i) disable iff (rst_i)
      en_i |=> data_o[ORDER-1:0] == state_q); // R3

   AST_RESET_SEED: assert property (@(posedge clk_i)
      $past(rst_i) |-> (state_q == SEED && data_o == '0)); // R4

endmodule

bind prbs7_par_gen prbs7_par_gen_chk #(
   .WIDTH (WIDTH),
   .SEED  (SEED)
) u_chk (
   .clk_i   (clk_i),
   .rst_i   (rst_i),
   .en_i    (en_i),
   .data_o  (data_o),
   .state_q (state_q)
);

// File: tb/tb_prbs7_par_gen.sv
module tb_prbs7_par_gen;

   localparam int CLK_PERIOD = 10;
   localparam int NWORDS     = 300;

   logic clk = 1'b0;
   logic rst;
   logic en;
   logic [7:0]  d8;
   logic [15:0] d16;

   always #(CLK_PERIOD/2) clk = ~clk;

   prbs7_par_gen #(.WIDTH(8))  dut   (.clk_i(clk), .rst_i(rst), .en_i(en), .data_o(d8));
   prbs7_par_gen #(.WIDTH(16)) dut16 (.clk_i(clk), .rst_i(rst), .en_i(en), .data_o(d16));

   int checks = 0;
   int errors = 0;
   logic [6:0] r8, r16;
   logic [7:0] hist [0:NWORDS-1];
   logic [7:0]  last8;
   logic [15:0] last16;
   int zrun, zmax;

   // bit-serial reference of x^7 + x^6 + 1, earliest bit ends up in MSB
   function automatic logic [15:0] ref_word(inout logic [6:0] s, input int w);
      logic [15:0] acc = '0;
      for (int i = 0; i < w; i++) begin
         logic b = s[6] ^ s[5];
         s   = {s[5:0], b};
         acc = {acc[14:0], b};
      end
      return acc;
   endfunction

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tally_zeros(input logic [7:0] w);
      for (int i = 7; i >= 0; i--) begin
         if (w[i]) zrun = 0;
         else begin
            zrun++;
            if (zrun > zmax) zmax = zrun;
         end
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst = 1'b1; en = 1'b0; zrun = 0; zmax = 0;
      repeat (3) @(negedge clk);
      chk("R4 reset w8",  {8'h00, d8}, 16'h0000);
      chk("R4 reset w16", d16, 16'h0000);

      rst = 1'b0;
      repeat (2) @(negedge clk);
      chk("R5 idle after reset", {8'h00, d8}, 16'h0000);

      r8 = 7'h7F; r16 = 7'h7F;
      en = 1'b1;
      for (int k = 0; k < NWORDS; k++) begin
         logic [15:0] e8, e16;
         @(negedge clk);
         e8  = ref_word(r8, 8);
         e16 = ref_word(r16, 16);
         hist[k] = d8;
         tally_zeros(d8);
         chk(k == 0 ? "R2 first word" : "R3 R1 word", {8'h00, d8}, e8);
         chk("R8 wide word", d16, e16);
      end

      for (int k = 0; k + 127 < NWORDS; k++)
         chk("R6 period", {8'h00, hist[k+127]}, {8'h00, hist[k]});
      chk("R6 no early repeat", {15'h0, hist[63] == hist[0] && hist[64] == hist[1]}, 16'h0);

      // hold with enable low
      en = 1'b0;
      last8 = d8; last16 = d16;
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         chk("R5 hold w8",  {8'h00, d8}, {8'h00, last8});
         chk("R5 hold w16", d16, last16);
      end
      en = 1'b1;
      @(negedge clk);
      chk("R5 resume w8",  {8'h00, d8}, ref_word(r8, 8));
      chk("R5 resume w16", d16, ref_word(r16, 16));
      tally_zeros(d8);

      // toggling enable
      for (int k = 0; k < 20; k++) begin
         logic [15:0] e8, e16;
         en = k[0];
         last8 = d8; last16 = d16;
         @(negedge clk);
         if (en) begin
            e8  = ref_word(r8, 8);
            e16 = ref_word(r16, 16);
            tally_zeros(d8);
         end else begin
            e8  = {8'h00, last8};
            e16 = last16;
         end
         chk("R5 toggle w8",  {8'h00, d8}, e8);
         chk("R5 toggle w16", d16, e16);
      end

      // reset in mid-run with enable high
      en = 1'b1; rst = 1'b1;
      @(negedge clk);
      chk("R9 R4 midrun reset", {8'h00, d8}, 16'h0000);
      rst = 1'b0;
      r8 = 7'h7F; r16 = 7'h7F;
      @(negedge clk);
      chk("R9 restart w8",  {8'h00, d8}, {8'h00, hist[0]});
      chk("R9 restart w16", d16, ref_word(r16, 16));

      chk("R7 longest zero run", 16'(zmax), 16'd6);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule